// File: doc/BRIEF.md
# Periodic Compare Interrupt Timer

The block produces interrupts at a fixed rate. A prescale stage divides the input clock by a programmable amount. Each time it wraps, a wide free-running counter steps by one. Each compare channel holds a target count. When the free-running counter steps onto that target, the channel raises its flag. In the same clock the channel moves its target forward by its own update amount, so the flags repeat at a fixed interval with no help from software. The block also raises a separate flag when the free-running counter reaches its all-ones value. The counter then wraps to zero and keeps counting.

Software programs the block through a small write port. Address 0 holds the prescale limit. For channel i, address 2i+1 holds the compare target and address 2i+2 holds the update amount. A counter-clear command zeroes the prescale and free-running counters but leaves every programmed register untouched. A clear just before a match therefore postpones that match, and the spacing of later matches stays the same. The flags are sticky and are cleared by writing one. Each interrupt output is its flag gated by its enable bit.

Top module: `tick_timer`

## Requirements
- R1: After the asynchronous reset, the free-running counter, the prescale counter, all flags, all interrupt outputs and all programmed registers are zero.
- R2: While `cnt_en` is high, the free-running counter steps by one every P+1 clocks, where P is the prescale limit at address 0. While `cnt_en` is low, both counters hold their values.
- R3: On the clock edge at which the free-running counter steps to all ones, the overflow flag (flag bit NUM_CMP) sets. The next step wraps the counter to zero, and counting then continues.
- R4: The flag of channel i (flag bit i) sets on the clock edge at which the free-running counter steps onto the value of that channel's compare target (address 2i+1). Channels act independently.
- R5: On each match, the channel's compare target becomes target plus update amount (address 2i+2), modulo 2^CNT_W. Matches therefore repeat every update×(P+1) clocks.
- R6: `cnt_clr` zeroes both counters, and in the same cycle it overrides a prescale wrap, so no step or match occurs. It leaves the prescale limit, the targets and the update amounts unchanged: the next match is postponed and later matches keep the same spacing.
- R7: A write to a compare target takes effect in the next cycle and overrides that cycle's automatic advance. A written update amount is first used at the next match.
- R8: Flags stay set until a one is written to their bit of `flag_clr`. A flag that sets in the same cycle as a clear stays set. `irq_o` is the bitwise AND of the flags and `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Counting enable |
| cnt_clr | input | 1 | Clears the prescale and free-running counters |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address (0 prescale, 2i+1 target, 2i+2 update) |
| wr_data | input | CNT_W | Register write data |
| irq_en | input | NUM_CMP+1 | Interrupt enable per flag |
| flag_clr | input | NUM_CMP+1 | Write-one-to-clear per flag |
| flags_o | output | NUM_CMP+1 | Sticky flags (bits 0..NUM_CMP-1 channels, bit NUM_CMP overflow) |
| irq_o | output | NUM_CMP+1 | Gated interrupt outputs |
| frc_o | output | CNT_W | Free-running counter value |

## Verification
The checker watches these properties on every cycle: the free-running counter only holds or steps by one, it stays put while disabled, a clear always leaves it at zero, the overflow flag sets on arrival at all ones, a channel flag rises only on a counter step, and flags stay set until cleared. Only the bench scenarios can show the timing of each match: that a match lands exactly update×(P+1) clocks after the previous one, that a clear postpones a match without changing later spacing, and that a written update amount is first used at the following match. The bench also covers a target write that overrides the automatic advance and a set that wins over a simultaneous clear.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

   typedef enum logic [1:0] {
      REG_NONE,
      REG_PRESCALE,
      REG_TARGET,
      REG_STEP
   } reg_kind_e;

   function automatic reg_kind_e reg_kind(input int unsigned addr, input int unsigned num_cmp);
      if (addr == 0)
         return REG_PRESCALE;
      else if (addr <= 2 * num_cmp)
         return (addr[0]) ? REG_TARGET : REG_STEP;
      else
         return REG_NONE;
   endfunction

   function automatic int unsigned reg_chan(input int unsigned addr);
      return (addr == 0) ? 0 : (addr - 1) / 2;
   endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
   parameter int PRE_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clr,
   input  logic             lim_we,
   input  logic [PRE_W-1:0] lim_wdata,
   output logic             tick_o
);

   logic [PRE_W-1:0] lim_q;
   logic [PRE_W-1:0] cnt_q;
   logic             at_lim;

   // A limit lowered below the running count wraps at once instead of
   // running through the whole range.
   assign at_lim = (cnt_q >= lim_q);
   assign tick_o = en && !clr && at_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lim_q <= '0;
      else if (lim_we)
         lim_q <= lim_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (en)
         cnt_q <= at_lim ? '0 : cnt_q + PRE_W'(1);
   end

endmodule

// File: rtl/tick_freerun.sv
module tick_freerun #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   output logic [CNT_W-1:0] frc_o,
   output logic [CNT_W-1:0] frc_next_o,
   output logic             ovf_evt_o
);

   logic [CNT_W-1:0] frc_q;

   assign frc_next_o = frc_q + CNT_W'(1);
   assign ovf_evt_o  = tick && (&frc_next_o);
   assign frc_o      = frc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         frc_q <= '0;
      else if (clr)
         frc_q <= '0;
      else if (tick)
         frc_q <= frc_next_o;
   end

endmodule

// File: rtl/tick_compare.sv
module tick_compare #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] frc_next,
   input  logic             tgt_we,
   input  logic             step_we,
   input  logic [CNT_W-1:0] wdata,
   output logic             match_o
);

   logic [CNT_W-1:0] tgt_q;
   logic [CNT_W-1:0] step_q;

   assign match_o = tick && (frc_next == tgt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tgt_q <= '0;
      else if (tgt_we)
         tgt_q <= wdata;
      else if (match_o)
         tgt_q <= tgt_q + step_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         step_q <= '0;
      else if (step_we)
         step_q <= wdata;
   end

endmodule

// File: rtl/tick_flags.sv
module tick_flags #(
   parameter int NF = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set_i,
   input  logic [NF-1:0] clr_i,
   input  logic [NF-1:0] en_i,
   output logic [NF-1:0] flags_o,
   output logic [NF-1:0] irq_o
);

   logic [NF-1:0] flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flags_q <= '0;
      else
         flags_q <= (flags_q & ~clr_i) | set_i;
   end

   assign flags_o = flags_q;
   assign irq_o   = flags_q & en_i;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int PRE_W   = 16,
   parameter int NUM_CMP = 2,
   localparam int NF     = NUM_CMP + 1,
   localparam int ADDR_W = $clog2(2 * NUM_CMP + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic              cnt_clr,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [NF-1:0]     irq_en,
   input  logic [NF-1:0]     flag_clr,
   output logic [NF-1:0]     flags_o,
   output logic [NF-1:0]     irq_o,
   output logic [CNT_W-1:0]  frc_o
);

   if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cnt_w
      $error("tick_timer: CNT_W must lie in 2..64");
   end
   if (PRE_W < 1 || PRE_W > CNT_W) begin : g_bad_pre_w
      $error("tick_timer: PRE_W must lie in 1..CNT_W");
   end
   if (NUM_CMP < 1 || NUM_CMP > 8) begin : g_bad_num_cmp
      $error("tick_timer: NUM_CMP must lie in 1..8");
   end

   reg_kind_e        kind;
   int unsigned      chan;
   logic             lim_we;
   logic             tick;
   logic             ovf_evt;
   logic [CNT_W-1:0] frc_next;
   logic [NF-1:0]    set_vec;

   always_comb begin
      kind   = reg_kind(32'(wr_addr), NUM_CMP);
      chan   = reg_chan(32'(wr_addr));
      lim_we = wr_en && (kind == REG_PRESCALE);
   end

   tick_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (cnt_en),
      .clr       (cnt_clr),
      .lim_we    (lim_we),
      .lim_wdata (wr_data[PRE_W-1:0]),
      .tick_o    (tick)
   );

   tick_freerun #(.CNT_W(CNT_W)) u_frc (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (cnt_clr),
      .tick       (tick),
      .frc_o      (frc_o),
      .frc_next_o (frc_next),
      .ovf_evt_o  (ovf_evt)
   );

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_chan
      logic tgt_we;
      logic step_we;
      assign tgt_we  = wr_en && (kind == REG_TARGET) && (chan == i);
      assign step_we = wr_en && (kind == REG_STEP) && (chan == i);

      tick_compare #(.CNT_W(CNT_W)) u_cmp (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (tick),
         .frc_next (frc_next),
         .tgt_we   (tgt_we),
         .step_we  (step_we),
         .wdata    (wr_data),
         .match_o  (set_vec[i])
      );
   end

   assign set_vec[NUM_CMP] = ovf_evt;

   tick_flags #(.NF(NF)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_vec),
      .clr_i   (flag_clr),
      .en_i    (irq_en),
      .flags_o (flags_o),
      .irq_o   (irq_o)
   );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
   parameter int CNT_W   = 32,
   parameter int NUM_CMP = 2,
   localparam int NF     = NUM_CMP + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_en,
   input logic             cnt_clr,
   input logic [NF-1:0]    flag_clr,
   input logic [NF-1:0]    flags_o,
   input logic [CNT_W-1:0] frc_o
);

   localparam logic [CNT_W-1:0] MAXV = '1;

   // R2: the counter only holds or steps by one unless cleared
   p_frc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_clr |=> (frc_o == $past(frc_o)) || (frc_o == $past(frc_o) + CNT_W'(1)));

   // R2: disabled counting holds the counter
   p_frc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !cnt_clr) |=> $stable(frc_o));

   // R6: a clear leaves the counter at zero
   p_clr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> (frc_o == '0));

   // R3: arrival at all ones raises the overflow flag
   p_ovf_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((frc_o == MAXV) && ($past(frc_o) != MAXV)) |-> flags_o[NUM_CMP]);

   // R8: flags not being cleared stay set
   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(flags_o & ~flag_clr)) |=>
         ((flags_o & $past(flags_o & ~flag_clr)) == $past(flags_o & ~flag_clr)));

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_chk
      // R4: a channel flag rises only on a counter step
      p_cmp_on_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flags_o[i]) |-> (frc_o != $past(frc_o)));
   end

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_chk (.*);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;

   localparam int CNT_W   = 10;
   localparam int PRE_W   = 8;
   localparam int NUM_CMP = 2;
   localparam int NF      = NUM_CMP + 1;
   localparam int ADDR_W  = $clog2(2 * NUM_CMP + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cnt_en = 1'b0;
   logic              cnt_clr = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [CNT_W-1:0]  wr_data = '0;
   logic [NF-1:0]     irq_en = '0;
   logic [NF-1:0]     flag_clr = '0;
   logic [NF-1:0]     flags_o;
   logic [NF-1:0]     irq_o;
   logic [CNT_W-1:0]  frc_o;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   tick_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W), .NUM_CMP(NUM_CMP)) u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_clr(cnt_clr),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .irq_en(irq_en), .flag_clr(flag_clr),
      .flags_o(flags_o), .irq_o(irq_o), .frc_o(frc_o)
   );

   // prescale limit, enabled clocks, expected counter value
   typedef struct packed {
      logic [7:0]  pre;
      logic [15:0] cycles;
      logic [15:0] exp_frc;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{pre: 8'd0, cycles: 16'd7,  exp_frc: 16'd7},
      '{pre: 8'd1, cycles: 16'd9,  exp_frc: 16'd4},
      '{pre: 8'd3, cycles: 16'd20, exp_frc: 16'd5},
      '{pre: 8'd4, cycles: 16'd14, exp_frc: 16'd2},
      '{pre: 8'd9, cycles: 16'd50, exp_frc: 16'd5},
      '{pre: 8'd0, cycles: 16'd0,  exp_frc: 16'd0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic run(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic wr(input int addr, input int data);
      wr_en   = 1'b1;
      wr_addr = ADDR_W'(addr);
      wr_data = CNT_W'(data);
      run(1);
      wr_en   = 1'b0;
   endtask

   task automatic clr_flags(input logic [NF-1:0] m);
      flag_clr = m;
      run(1);
      flag_clr = '0;
   endtask

   task automatic clr_cnt();
      cnt_clr = 1'b1;
      run(1);
      cnt_clr = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      run(3);
      rst_n = 1'b1;
      run(1);
      // R1 reset state
      check("R1 frc", 32'(frc_o), 0);
      check("R1 flags", 32'(flags_o), 0);
      check("R1 irq", 32'(irq_o), 0);

      // R2 prescale vectors
      for (int v = 0; v < NV; v++) begin
         wr(0, int'(VECS[v].pre));
         clr_cnt();
         cnt_en = 1'b1;
         run(int'(VECS[v].cycles));
         cnt_en = 1'b0;
         check($sformatf("R2 vec %0d", v), 32'(frc_o), 32'(VECS[v].exp_frc));
      end
      run(5);
      check("R2 hold while disabled", 32'(frc_o), 0);

      // R4 / R5 periodic compare, prescale 1
      wr(0, 1);
      wr(1, 5);
      wr(2, 3);
      clr_flags('1);
      clr_cnt();
      cnt_en = 1'b1;
      run(9);
      check("R4 no flag before match", 32'(flags_o[0]), 0);
      run(1);
      check("R4 flag at match", 32'(flags_o[0]), 1);
      check("R4 frc at match", 32'(frc_o), 5);
      check("R8 irq gated off", 32'(irq_o[0]), 0);
      irq_en[0] = 1'b1;
      #1;
      check("R8 irq enabled", 32'(irq_o[0]), 1);
      clr_flags(3'b001);
      check("R8 w1c clears", 32'(flags_o[0]), 0);
      run(4);
      check("R5 no early match", 32'(flags_o[0]), 0);
      run(1);
      check("R5 second match", 32'(flags_o[0]), 1);
      check("R5 frc second match", 32'(frc_o), 8);

      // R6 clear on the tick edge just before the match at 11
      clr_flags(3'b001);
      run(4);
      cnt_clr = 1'b1;
      run(1);
      cnt_clr = 1'b0;
      check("R6 frc zero", 32'(frc_o), 0);
      check("R6 match suppressed", 32'(flags_o[0]), 0);
      run(21);
      check("R6 postponed no flag", 32'(flags_o[0]), 0);
      check("R6 frc before match", 32'(frc_o), 10);
      run(1);
      check("R6 postponed match", 32'(flags_o[0]), 1);
      check("R6 frc postponed", 32'(frc_o), 11);
      clr_flags(3'b001);
      run(4);
      check("R6 interval kept early", 32'(flags_o[0]), 0);
      run(1);
      check("R6 interval kept", 32'(flags_o[0]), 1);
      check("R6 frc next", 32'(frc_o), 14);

      // R7 update write used from the next match (target already 17)
      cnt_en = 1'b0;
      wr(2, 5);
      clr_flags(3'b001);
      cnt_en = 1'b1;
      run(5);
      check("R7 pending match", 32'(flags_o[0]), 0);
      run(1);
      check("R7 old target match", 32'(frc_o), 17);
      clr_flags(3'b001);
      run(8);
      check("R7 before new spacing", 32'(flags_o[0]), 0);
      run(1);
      check("R7 new spacing", 32'(flags_o[0]), 1);
      check("R7 frc new spacing", 32'(frc_o), 22);

      // R7 target write takes effect at once (advance would give 27)
      cnt_en = 1'b0;
      wr(1, 25);
      clr_flags(3'b001);
      cnt_en = 1'b1;
      run(5);
      check("R7 written target early", 32'(flags_o[0]), 0);
      run(1);
      check("R7 written target match", 32'(flags_o[0]), 1);
      check("R7 frc written target", 32'(frc_o), 25);

      // R3 overflow and wrap, prescale 0
      cnt_en = 1'b0;
      wr(0, 0);
      clr_flags('1);
      clr_cnt();
      cnt_en = 1'b1;
      run(1022);
      check("R3 no flag before max", 32'(flags_o[NUM_CMP]), 0);
      run(1);
      check("R3 frc at max", 32'(frc_o), 32'h3FF);
      check("R3 overflow flag", 32'(flags_o[NUM_CMP]), 1);
      check("R8 overflow irq gated", 32'(irq_o[NUM_CMP]), 0);
      run(1);
      check("R3 wrap to zero", 32'(frc_o), 0);
      check("R4 channel 1 match at zero", 32'(flags_o[1]), 1);
      run(3);
      check("R3 counting continues", 32'(frc_o), 3);

      // R8 set wins over clear on channel 1
      cnt_en = 1'b0;
      wr(3, 10);
      cnt_en = 1'b1;
      run(6);
      check("R8 sticky flag", 32'(flags_o[1]), 1);
      flag_clr = 3'b010;
      run(1);
      flag_clr = '0;
      check("R8 frc at set", 32'(frc_o), 10);
      check("R8 set wins clear", 32'(flags_o[1]), 1);
      check("R8 overflow still sticky", 32'(flags_o[NUM_CMP]), 1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule